// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a successive-approximation analog-to-digital converter. An external convert-request line is watched for its high-to-low transition. When that transition arrives and the block is idle, the block loads its result register with all ones and raises `busy`. `busy` is also the enable of the internal stepping clock. While it is high, the block runs exactly WIDTH+1 steps. In each step it presents a trial code to an external feedback DAC, reads a single comparator bit, and settles one result bit, working from the most significant bit down.

The coding is complementary. The bit under test is driven to 0, and every bit not yet tried is held at 1. A comparator input of 1 means the analog input lies at or above the DAC level for the current trial, and the trial 0 is then kept. After the final step `busy` drops and the stepping enable returns low. The code stays frozen until the next request. The same register drives both the DAC and the parallel result pins, so the result is visible at all times.

Top module: `sar_gated_ctrl`

## Requirements
- R1: After the synchronous active-high reset, `busy` is 0 and `sar_code` is all ones.
- R2: A conversion starts only on a falling transition of `conv_start`: a cycle in which it was sampled high, followed by a cycle in which it is sampled low. `busy` reads 1 after that second edge. Holding `conv_start` high never starts one.
- R3: `busy` stays high for exactly WIDTH+1 consecutive clock cycles per conversion (17 for WIDTH=16).
- R4: After the first step, `sar_code` has bit WIDTH-1 at 0 and all lower bits at 1.
- R5: At step k (k = 1..WIDTH), bit WIDTH-k takes the value 0 if `cmp_above` was 1 and the value 1 otherwise. In the same step, bit WIDTH-k-1 (when it exists) is driven to 0, and already decided bits are unchanged.
- R6: With an ideal comparator, `cmp_above` = (input >= level), where level is the bitwise inverse of `sar_code`. Under that comparator the final code is the bitwise inverse of the input value.
- R7: A falling transition of `conv_start` during a conversion is ignored. The run still lasts WIDTH+1 cycles and yields the same result.
- R8: While idle, `sar_code` holds its value whatever `cmp_above` does.
- R9: Reset during a conversion aborts it: `busy` returns to 0 and `sar_code` to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_start | input | 1 | Convert request; its falling transition starts a conversion |
| cmp_above | input | 1 | Comparator: 1 when the analog input is at or above the DAC level |
| busy | output | 1 | Conversion in progress; enable of the stepping clock |
| sar_code | output | WIDTH | Trial code to the DAC and parallel result (complementary binary) |

## Verification
The bench builds the block with WIDTH=16, so each run covers the full 17-step window and every bit position in turn. The comparator is modelled as a digital compare against a target value. With this width, the extreme targets 0 and 0xFFFF force every decision the same way. Alternating and single-bit patterns exercise each keep/restore choice. Exact ties at a trial level exercise the keep-on-equal case. A second falling edge mid-run checks that restarts are ignored, and a reset inside a run checks abort.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CONV = 1'b1
  } conv_state_e;
endpackage

// File: rtl/sar_fall_detect.sv
module sar_fall_detect (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level_i;
  end

  assign fall_o = prev_q & ~level_i;

  // R2: a detected fall must follow a cycle with the request high
  p_fall_after_high_r2: assert property (@(posedge clk) disable iff (rst)
    fall_o |-> $past(level_i));
endmodule

// File: rtl/sar_step_seq.sv
module sar_step_seq
  import sar_ctrl_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fall_i,
  output logic             busy_o,
  output logic             arm_o,
  output logic [CNT_W-1:0] idx_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH);

  conv_state_e      state_q;
  logic [CNT_W-1:0] idx_q;

  assign arm_o  = fall_i && (state_q == ST_IDLE);
  assign busy_o = (state_q == ST_CONV);
  assign idx_o  = idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (fall_i) begin
            state_q <= ST_CONV;
            idx_q   <= '0;
          end
        end
        ST_CONV: begin
          if (idx_q == LAST) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2: an accepted request opens the run at step zero
  p_arm_opens_run_r2: assert property (@(posedge clk) disable iff (rst)
    arm_o |=> (busy_o && idx_q == '0));

  // R3: the run closes right after its final step
  p_run_closes_r3: assert property (@(posedge clk) disable iff (rst)
    (busy_o && idx_q == LAST) |=> !busy_o);

  // R7: mid-run requests neither restart nor stall the step count
  p_no_restart_r7: assert property (@(posedge clk) disable iff (rst)
    (busy_o && idx_q != LAST) |=> (busy_o && idx_q == $past(idx_q) + CNT_W'(1)));
endmodule

// File: rtl/sar_code_reg.sv
module sar_code_reg #(
  parameter int WIDTH = 16,
  parameter int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm_i,
  input  logic             busy_i,
  input  logic [CNT_W-1:0] idx_i,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] code_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    localparam logic [CNT_W-1:0] TRIAL_AT  = CNT_W'(WIDTH - 1 - i);
    localparam logic [CNT_W-1:0] DECIDE_AT = CNT_W'(WIDTH - i);
    logic q;

    always_ff @(posedge clk) begin
      if (rst || arm_i) begin
        q <= 1'b1;
      end else if (busy_i) begin
        if (idx_i == DECIDE_AT)     q <= ~cmp_i;
        else if (idx_i == TRIAL_AT) q <= 1'b0;
      end
    end

    assign code_o[i] = q;

    // R5: the decision step stores the inverted comparator bit
    p_decide_r5: assert property (@(posedge clk) disable iff (rst)
      (busy_i && !arm_i && idx_i == DECIDE_AT) |=> (q == !$past(cmp_i)));
  end

  // R4: the first step drives only the top bit low
  p_first_trial_r4: assert property (@(posedge clk) disable iff (rst)
    (busy_i && idx_i == '0) |=> (code_o == {1'b0, {(WIDTH-1){1'b1}}}));

  // R8: the code is frozen while idle
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy_i && !arm_i) |=> $stable(code_o));
endmodule

// File: rtl/sar_gated_ctrl.sv
module sar_gated_ctrl #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             conv_start,
  input  logic             cmp_above,
  output logic             busy,
  output logic [WIDTH-1:0] sar_code
);
  localparam int CNT_W = $clog2(WIDTH + 1);

  logic             fall;
  logic             arm;
  logic [CNT_W-1:0] idx;

  sar_fall_detect u_fall (
    .clk     (clk),
    .rst     (rst),
    .level_i (conv_start),
    .fall_o  (fall)
  );

  sar_step_seq #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .fall_i (fall),
    .busy_o (busy),
    .arm_o  (arm),
    .idx_o  (idx)
  );

  sar_code_reg #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_code (
    .clk    (clk),
    .rst    (rst),
    .arm_i  (arm),
    .busy_i (busy),
    .idx_i  (idx),
    .cmp_i  (cmp_above),
    .code_o (sar_code)
  );

  // R1/R9: reset returns the block to idle with the all-ones code
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!busy && sar_code == {WIDTH{1'b1}}));
endmodule

// File: tb/sar_gated_ctrl_tb_top.sv
module sar_gated_ctrl_tb_top;
  localparam int W          = 16;
  localparam int CLK_PERIOD = 10;
  localparam int RUN_LEN    = W + 1;
  localparam int WDOG       = 100000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         conv_start = 1'b0;
  logic [W-1:0] target = '0;
  logic         cmp_above;
  logic         busy;
  logic [W-1:0] sar_code;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  // ideal comparator: level represented by the complement of the code
  assign cmp_above = (target >= ~sar_code);

  sar_gated_ctrl #(.WIDTH(W)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .conv_start (conv_start),
    .cmp_above  (cmp_above),
    .busy       (busy),
    .sar_code   (sar_code)
  );

  task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  int           busy_run = 0;
  logic [W-1:0] step_exp;
  always @(negedge clk) begin
    if (rst) begin
      busy_run = 0;
    end else if (busy) begin
      busy_run++;
      if (busy_run == 2)
        check_eq("R4 first trial code", sar_code, {1'b0, {(W-1){1'b1}}});
      if (busy_run >= 2 && busy_run <= RUN_LEN) begin
        step_exp = '1;
        for (int i = 0; i < busy_run - 2; i++) step_exp[W-1-i] = ~target[W-1-i];
        step_exp[W-busy_run+1] = 1'b0;
        check_eq("R5 per-step code", sar_code, step_exp);
      end
    end else if (busy_run > 0) begin
      check_eq("R3 busy length", busy_run, RUN_LEN);
      if (exp_q.size() == 0) begin
        check_eq("R6 unexpected result", sar_code, 32'hDEAD);
      end else begin
        check_eq("R6 final code", sar_code, exp_q.pop_front());
      end
      busy_run = 0;
    end
  end

  task automatic convert(input logic [W-1:0] t, input bit glitch);
    @(negedge clk);
    target = t;
    exp_q.push_back(~t);
    conv_start = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check_eq("R2 no start while held high", busy, 0);
    end
    conv_start = 1'b0;
    @(negedge clk);
    check_eq("R2 busy after falling edge", busy, 1);
    if (glitch) begin
      repeat (4) @(negedge clk);
      conv_start = 1'b1;
      repeat (2) @(negedge clk);
      conv_start = 1'b0;   // R7: falling edge mid-run
    end
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_all();
    logic [W-1:0] held;
    logic [W-1:0] lcg;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_eq("R1 reset busy", busy, 0);
    check_eq("R1 reset code", sar_code, {W{1'b1}});

    convert(16'h0000, 1'b0);
    convert(16'hFFFF, 1'b0);
    convert(16'h8000, 1'b0);
    convert(16'h7FFF, 1'b0);
    convert(16'h5555, 1'b0);
    convert(16'hAAAA, 1'b0);
    convert(16'h677A, 1'b0);
    convert(16'h0001, 1'b0);
    convert(16'h3C5A, 1'b1);   // R7
    convert(16'hC3A5, 1'b1);   // R7

    // R8: comparator activity while idle
    held = sar_code;
    for (int k = 0; k < 8; k++) begin
      target = 16'h1111 * k[W-1:0];
      @(negedge clk);
      check_eq("R8 idle code hold", sar_code, held);
      check_eq("R8 idle busy", busy, 0);
    end

    // R9: abort by reset mid-conversion
    target = 16'h4321;
    conv_start = 1'b1;
    @(negedge clk);
    conv_start = 1'b0;
    repeat (6) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_eq("R9 abort busy", busy, 0);
    check_eq("R9 abort code", sar_code, {W{1'b1}});

    lcg = 16'hACE1;
    for (int n = 0; n < 12; n++) begin
      lcg = lcg * 16'd25173 + 16'd13849;
      convert(lcg, n[0]);
    end
    check_eq("R6 scoreboard drained", exp_q.size(), 0);
  endtask

  initial begin
    bit timed_out;
    timed_out = 1'b0;
    fork
      run_all();
      begin
        repeat (WDOG) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule